// File: doc/BRIEF.md
# ADC Result Formatter and Router

This block takes return messages from an on-chip converter interface and turns each one into a 16-bit result word. It pushes that word into one of several result FIFOs, picked by the message's 4-bit tag. A message is one of three payload kinds:

- a value read back from a converter register;
- a time-base value captured when input sampling ends;
- a conversion sample.

Register values and time-base values are stored without change. A conversion sample arrives right-aligned at 8, 10 or 12 bits. It is first moved up into a 12-bit word whose MSB sits at bit 11. That word is then shifted left by two, which gives a 14-bit field right-justified in the 16-bit output with bits 15:14 at zero. If the originating command asked for calibration, the 14-bit field comes instead from a separate calibrated-data input.

The input side uses a valid/ready handshake. The block never drops a message: it holds ready low while the addressed FIFO is full, or while a push to that same FIFO is still on the output. The output is registered, so the push strobe and the write data appear one clock after a message is accepted. A tag that names no FIFO is accepted, causes no push, and raises a one-cycle error pulse.

A small controller tracks what the output registers hold, using three states:

- `ST_IDLE` means nothing is being pushed.
- `ST_PUSH` means a push strobe is active.
- `ST_FAULT` means the error pulse is active.

Transitions are taken on every clock edge:

- Any state goes to `ST_PUSH` when a message with a valid tag is accepted.
- Any state goes to `ST_FAULT` when a message with an out-of-range tag is accepted.
- Any state goes to `ST_IDLE` when no message is accepted.

Top module: `adc_result_router`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fifo_push` is all zero and `tag_err` is low.
- R2: A message of kind 2'b00 (register read) is written unchanged. The reserved kind 2'b11 is treated the same way.
- R3: A message of kind 2'b01 (time stamp) is written unchanged.
- R4: An uncalibrated conversion (kind 2'b10, `msg_cal`=0) with resolution code 2'b00 (12-bit) or 2'b11 (also 12-bit) writes {2'b00, data[11:0], 2'b00}.
- R5: An uncalibrated conversion with resolution code 2'b01 (10-bit) writes {2'b00, data[9:0], 4'b0000}.
- R6: An uncalibrated conversion with resolution code 2'b10 (8-bit) writes {2'b00, data[7:0], 6'b000000}.
- R7: A conversion with `msg_cal`=1 writes {2'b00, cal_data}. `msg_cal` has no effect on the other kinds.
- R8: An accepted message whose tag is below NUM_FIFOS raises exactly bit `tag` of `fifo_push`, one cycle later and for one cycle. Without an accepted message, no push occurs.
- R9: An accepted message whose tag is NUM_FIFOS or above causes no push, and raises `tag_err` for one cycle, one cycle later.
- R10: `msg_ready` is low exactly when the tag is valid and either `fifo_full[tag]` is set or `fifo_push[tag]` is currently high. A message held off this way produces no push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A return message is present |
| msg_ready | output | 1 | The message is taken on this edge |
| msg_tag | input | TAG_W | Target FIFO index |
| msg_kind | input | 2 | Payload kind: 00 register, 01 time stamp, 10 conversion, 11 as 00 |
| msg_cal | input | 1 | Calibration requested by the command |
| msg_res | input | 2 | Sample resolution: 00 12-bit, 01 10-bit, 10 8-bit, 11 12-bit |
| msg_data | input | 16 | Raw payload |
| cal_data | input | 14 | Calibrated 14-bit value for this message |
| fifo_full | input | NUM_FIFOS | Full flag of each result FIFO |
| fifo_push | output | NUM_FIFOS | Push strobe of each result FIFO |
| fifo_wdata | output | 16 | Write data shared by all FIFOs |
| tag_err | output | 1 | One-cycle pulse for an out-of-range tag |

## Verification
The assertions check the following on every cycle:

- at most one push strobe is active at a time;
- every push or error pulse traces back to an acceptance in the previous cycle;
- ready drops whenever a valid tag meets a full FIFO;
- a conversion result has zero upper bits;
- a time stamp passes through unchanged.

The exact bit placement for each resolution, the selection between the calibrated and shifted values, and the pass-through of the reserved kind can only be shown by the bench. It compares each written word against a model of the format rules, across random mixes of tags, kinds, resolutions and full flags, plus directed back-to-back and hold-off cases.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
    localparam int DATA_W   = 16;
    localparam int SAMPLE_W = 12;
    localparam int RESULT_W = 14;

    typedef enum logic [1:0] {
        KIND_REGRD = 2'b00,
        KIND_STAMP = 2'b01,
        KIND_CONV  = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_t;

    typedef enum logic [1:0] {
        RES_12  = 2'b00,
        RES_10  = 2'b01,
        RES_8   = 2'b10,
        RES_12B = 2'b11
    } res_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_PUSH  = 2'b01,
        ST_FAULT = 2'b10
    } rstate_t;
endpackage

// File: rtl/adcr_normalize.sv
module adcr_normalize
    import adcr_pkg::*;
(
    input  logic [1:0]          kind,
    input  logic                cal,
    input  logic [1:0]          res,
    input  logic [DATA_W-1:0]   raw,
    input  logic [RESULT_W-1:0] cal_val,
    output logic [DATA_W-1:0]   word
);
    localparam int PAD_W = DATA_W - RESULT_W;
    localparam int LSH   = RESULT_W - SAMPLE_W;

    logic [SAMPLE_W-1:0] aligned;
    logic [RESULT_W-1:0] shifted;
    logic [RESULT_W-1:0] field;

    // Move an 8/10/12-bit right-aligned sample so its MSB lands on bit 11
    always_comb begin
        unique case (res_t'(res))
            RES_10:  aligned = {raw[SAMPLE_W-3:0], 2'b00};
            RES_8:   aligned = {raw[SAMPLE_W-5:0], 4'b0000};
            default: aligned = raw[SAMPLE_W-1:0];
        endcase
    end

    assign shifted = {aligned, {LSH{1'b0}}};
    assign field   = cal ? cal_val : shifted;

    always_comb begin
        if (kind_t'(kind) == KIND_CONV) word = {{PAD_W{1'b0}}, field};
        else                            word = raw;
    end
endmodule

// File: rtl/adcr_tag_decode.sv
module adcr_tag_decode #(
    parameter int NUM_FIFOS = 6,
    parameter int TAG_W     = 4
) (
    input  logic [TAG_W-1:0]     tag,
    input  logic [NUM_FIFOS-1:0] full,
    input  logic [NUM_FIFOS-1:0] pending,
    output logic [NUM_FIFOS-1:0] sel,
    output logic                 tag_ok,
    output logic                 blocked
);
    for (genvar i = 0; i < NUM_FIFOS; i++) begin : g_sel
        assign sel[i] = (tag == TAG_W'(i));
    end

    assign tag_ok  = ({1'b0, tag} < (TAG_W+1)'(NUM_FIFOS));
    assign blocked = tag_ok && (|(sel & (full | pending)));
endmodule

// File: rtl/adc_result_router.sv
module adc_result_router
    import adcr_pkg::*;
#(
    parameter int NUM_FIFOS = 6,
    parameter int TAG_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    output logic                 msg_ready,
    input  logic [TAG_W-1:0]     msg_tag,
    input  logic [1:0]           msg_kind,
    input  logic                 msg_cal,
    input  logic [1:0]           msg_res,
    input  logic [DATA_W-1:0]    msg_data,
    input  logic [RESULT_W-1:0]  cal_data,
    input  logic [NUM_FIFOS-1:0] fifo_full,
    output logic [NUM_FIFOS-1:0] fifo_push,
    output logic [DATA_W-1:0]    fifo_wdata,
    output logic                 tag_err
);
    rstate_t              state_q, state_d;
    logic [NUM_FIFOS-1:0] sel;
    logic                 tag_ok;
    logic                 blocked;
    logic                 accept;
    logic [DATA_W-1:0]    norm_word;
    logic [NUM_FIFOS-1:0] push_q;
    logic [DATA_W-1:0]    wdata_q;

    adcr_tag_decode #(.NUM_FIFOS(NUM_FIFOS), .TAG_W(TAG_W)) u_dec (
        .tag     (msg_tag),
        .full    (fifo_full),
        .pending (push_q),
        .sel     (sel),
        .tag_ok  (tag_ok),
        .blocked (blocked)
    );

    adcr_normalize u_norm (
        .kind    (msg_kind),
        .cal     (msg_cal),
        .res     (msg_res),
        .raw     (msg_data),
        .cal_val (cal_data),
        .word    (norm_word)
    );

    assign msg_ready = !blocked;
    assign accept    = msg_valid && msg_ready;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_PUSH, ST_FAULT: begin
                if (accept) state_d = tag_ok ? ST_PUSH : ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_q  <= '0;
            wdata_q <= '0;
        end else begin
            push_q <= (accept && tag_ok) ? sel : '0;
            if (accept && tag_ok) wdata_q <= norm_word;
        end
    end

    assign fifo_push  = push_q;
    assign fifo_wdata = wdata_q;
    assign tag_err    = (state_q == ST_FAULT);
endmodule

// File: rtl/adcr_checker.sv
module adcr_checker #(
    parameter int NUM_FIFOS = 6,
    parameter int TAG_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input logic [TAG_W-1:0]     msg_tag,
    input logic [1:0]           msg_kind,
    input logic [15:0]          msg_data,
    input logic [NUM_FIFOS-1:0] fifo_full,
    input logic [NUM_FIFOS-1:0] fifo_push,
    input logic [15:0]          fifo_wdata,
    input logic                 tag_err
);
    localparam int TAGS = 2 ** TAG_W;

    logic [TAGS-1:0] full_ext;
    logic            in_range;
    logic            acc;

    assign full_ext = TAGS'(fifo_full);
    assign in_range = ({1'b0, msg_tag} < (TAG_W+1)'(NUM_FIFOS));
    assign acc      = msg_valid && msg_ready;

    p_one_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_push));

    p_no_spurious_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (fifo_push == '0) && !tag_err);

    p_push_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_range) |=> ($countones(fifo_push) == 1) && !tag_err);

    p_bad_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_range) |=> tag_err && (fifo_push == '0));

    p_hold_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && in_range && full_ext[msg_tag]) |-> !msg_ready);

    p_conv_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_range && msg_kind == 2'b10) |=> fifo_wdata[15:14] == 2'b00);

    p_stamp_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_range && msg_kind == 2'b01) |=> fifo_wdata == $past(msg_data));
endmodule

bind adc_result_router adcr_checker #(.NUM_FIFOS(NUM_FIFOS), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_tag    (msg_tag),
    .msg_kind   (msg_kind),
    .msg_data   (msg_data),
    .fifo_full  (fifo_full),
    .fifo_push  (fifo_push),
    .fifo_wdata (fifo_wdata),
    .tag_err    (tag_err)
);

// File: tb/sim_adc_result_router.sv
`timescale 1ns/1ps
module sim_adc_result_router;
    localparam int NF = 6;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msg_valid = 1'b0;
    logic          msg_ready;
    logic [TW-1:0] msg_tag = '0;
    logic [1:0]    msg_kind = '0;
    logic          msg_cal = 1'b0;
    logic [1:0]    msg_res = '0;
    logic [15:0]   msg_data = '0;
    logic [13:0]   cal_data = '0;
    logic [NF-1:0] fifo_full = '0;
    logic [NF-1:0] fifo_push;
    logic [15:0]   fifo_wdata;
    logic          tag_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    adc_result_router #(.NUM_FIFOS(NF), .TAG_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_tag(msg_tag), .msg_kind(msg_kind), .msg_cal(msg_cal), .msg_res(msg_res),
        .msg_data(msg_data), .cal_data(cal_data), .fifo_full(fifo_full),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .tag_err(tag_err)
    );

    function automatic logic [15:0] model(input logic [1:0] k, input logic c,
                                          input logic [1:0] r, input logic [15:0] d,
                                          input logic [13:0] cd);
        if (k != 2'b10) return d;
        if (c) return {2'b00, cd};
        case (r)
            2'b01:   return {2'b00, d[9:0], 4'b0000};
            2'b10:   return {2'b00, d[7:0], 6'b000000};
            default: return {2'b00, d[11:0], 2'b00};
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one message at a negedge, checks ready, then checks outputs one cycle later.
    task automatic send(input logic [TW-1:0] t, input logic [1:0] k, input logic c,
                        input logic [1:0] r, input logic [15:0] d, input logic [13:0] cd,
                        input logic [NF-1:0] full, input string req);
        logic    exp_rdy;
        logic    ok_tag;
        logic [NF-1:0] exp_push;
        msg_tag = t; msg_kind = k; msg_cal = c; msg_res = r; msg_data = d;
        cal_data = cd; fifo_full = full; msg_valid = 1'b1;
        ok_tag  = (int'(t) < NF);
        exp_rdy = !(ok_tag && full[int'(t) % NF]);
        #1;
        chk(msg_ready == exp_rdy, "R10 ready", 32'(msg_ready), 32'(exp_rdy));
        @(negedge clk);
        exp_push = (exp_rdy && ok_tag) ? NF'(1) << t : '0;
        chk(fifo_push == exp_push, "R8 push", 32'(fifo_push), 32'(exp_push));
        chk(tag_err == (exp_rdy && !ok_tag), "R9 tag_err", 32'(tag_err),
            32'(exp_rdy && !ok_tag));
        if (exp_rdy && ok_tag)
            chk(fifo_wdata == model(k, c, r, d, cd), req, 32'(fifo_wdata),
                32'(model(k, c, r, d, cd)));
        msg_valid = 1'b0;
        fifo_full = '0;
        @(negedge clk);
        chk(fifo_push == '0 && !tag_err, "R8 single-cycle strobe", 32'(fifo_push), 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(fifo_push == '0 && !tag_err, "R1 reset outputs", 32'(fifo_push), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fifo_push == '0 && !tag_err, "R1 after reset", 32'(fifo_push), 0);

        send(4'd0, 2'b00, 1'b1, 2'b10, 16'hBEEF, 14'h1234, '0, "R2 register read");
        send(4'd5, 2'b11, 1'b0, 2'b01, 16'hC0DE, 14'h0, '0, "R2 reserved kind");
        send(4'd1, 2'b01, 1'b1, 2'b00, 16'hFFFF, 14'h3FFF, '0, "R3 time stamp");
        send(4'd2, 2'b10, 1'b0, 2'b00, 16'hFABC, 14'h0, '0, "R4 12-bit");
        send(4'd2, 2'b10, 1'b0, 2'b11, 16'h0FFF, 14'h0, '0, "R4 code 11");
        send(4'd3, 2'b10, 1'b0, 2'b01, 16'hF3FF, 14'h0, '0, "R5 10-bit");
        send(4'd4, 2'b10, 1'b0, 2'b10, 16'hFFA5, 14'h0, '0, "R6 8-bit");
        send(4'd4, 2'b10, 1'b1, 2'b10, 16'hFFA5, 14'h2AAA, '0, "R7 calibrated");
        send(4'd6, 2'b10, 1'b0, 2'b00, 16'h0123, 14'h0, '0, "R9 tag at limit");
        send(4'd15, 2'b00, 1'b0, 2'b00, 16'h0123, 14'h0, 6'h3F, "R9 tag max");
        send(4'd3, 2'b00, 1'b0, 2'b00, 16'h5555, 14'h0, 6'b001000, "R10 full");

        // Back-to-back: while a push to FIFO 2 is on the output, same tag is held off.
        msg_tag = 4'd2; msg_kind = 2'b00; msg_data = 16'h1111; msg_valid = 1'b1;
        @(negedge clk);
        chk(fifo_push == 6'b000100, "R8 first push", 32'(fifo_push), 32'h4);
        chk(msg_ready == 1'b0, "R10 pending same tag", 32'(msg_ready), 0);
        msg_tag = 4'd3; msg_data = 16'h2222;
        #1;
        chk(msg_ready == 1'b1, "R10 other tag free", 32'(msg_ready), 1);
        @(negedge clk);
        chk(fifo_push == 6'b001000 && fifo_wdata == 16'h2222, "R8 back-to-back",
            32'(fifo_wdata), 32'h2222);
        msg_valid = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 400; i++) begin
            send(TW'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                 16'($urandom()), 14'($urandom()), NF'($urandom()), "R4 R5 R6 R7 random word");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule